// File: doc/BRIEF.md
# Multi-Group Parallel Port Bank

This block is a bank of six identical general-purpose parallel port groups behind a small I/O-mapped bus. Each group has three 8-bit ports (A, B and C) that work only as simple static inputs or outputs. A control byte per group sets the direction of port A, of port B, and of each half of port C. Output pins are driven from per-port output latches through output enables. Input pins are read through as they stand at the moment of the read, with no capture register.

The bus has a 10-bit address, an 8-bit write data byte, one-cycle read and write strobes and a registered read data byte. The base address is a parameter and must lie between 0x200 and 0x3FF. A mode input picks the wide layout, which claims a 32-address window and reaches all six groups. The same input can pick the narrow layout, which claims 16 addresses and reaches groups 0 to 3 only. In the window, group g takes offsets 4g to 4g+3. In that order they hold port A, port B, port C and the control byte.

Top module: `pio_bank`

## Requirements
- R1: A synchronous reset sets every port to input, clears all output latches to 0, drives every output enable low and sets the read data register to 0x00.
- R2: An access hits only when address bit 9 is 1 and address bits 8 to 5 equal those of the base. A write that misses changes no latch and no direction, and a read that misses leaves the read data unchanged.
- R3: With mode_wide high the window is 32 addresses. Address bit 4 is left out of the base compare and, with bits 3 to 0, forms the 5-bit offset. Offset 4g+0/1/2/3 selects port A/B/C/control of group g.
- R4: With mode_wide low the window is 16 addresses. Address bit 4 must equal base bit 4, and the offset is bits 3 to 0, so only groups 0 to 3 are reachable.
- R5: A control write with data bit 7 set loads the directions: bit 4 for port A, bit 1 for port B, bit 3 for port C bits 7..4 and bit 0 for port C bits 3..0, where 1 means input. Each output enable bit is high exactly when its line is an output.
- R6: A control write with bit 7 set also clears the three output latches of that group to 0 and leaves other groups alone. A control write with bit 7 clear has no effect.
- R7: Reading a port, or a port C half, set as input returns the pin value present at the clock edge of the read, with no latching.
- R8: Reading a port, or a port C half, set as output returns its output latch. A split port C returns input pins in one half and latch bits in the other.
- R9: A read of a control offset, or of offsets 24 to 31 in the wide layout, returns 0xFF.
- R10: A data write to a port offset loads that port's output latch whatever its direction. pin_out always shows the latches, and pin_oe decides whether they drive.
- R11: Read data is registered. It changes on the clock edge where a hitting read strobe is high and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 1: 32-address, six-group layout; 0: 16-address, four-group layout |
| addr | input | 10 | I/O address |
| wdata | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| pin_in | input | 144 | Pin input levels, group g port p at bits 24g+8p |
| pin_out | output | 144 | Output latch values, same layout |
| pin_oe | output | 144 | Per-line output enable, 1 = drive |

## Verification
The bench splits a port C between an input half and an output half, and checks that the read data joins pin bits and latch bits correctly. A design that applied the direction to the whole byte would return one source only. It reads a wide-layout address with bit 4 set that the narrow layout must refuse. A decoder that compared bit 4 in both modes, or in neither, would miss the group 4 read or would answer outside its 16-byte window. It also writes control bytes with bit 7 clear and reads unmapped and control offsets. A design that acted on such bytes would clear latches, and one that routed those offsets to a group would return port data in place of 0xFF. Changing a pin between two reads exposes any input capture register, because such a design returns the old value.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;

  // Register select inside one group (offset bits 1:0)
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  // Direction state of one group, 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  localparam int CTL_LOAD_BIT = 7;

  function automatic dir_t ctl_to_dir(input logic [7:0] w);
    dir_t d;
    d.a_in  = w[4];
    d.b_in  = w[1];
    d.cu_in = w[3];
    d.cl_in = w[0];
    return d;
  endfunction

endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_bank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h2C0,
  parameter int NUM_GROUPS = 6,
  parameter int OFF_W = 5,
  localparam int GRP_W = OFF_W - 2
) (
  input  logic              mode_wide,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              mapped,
  output logic [GRP_W-1:0]  grp,
  output reg_sel_e          sel
);

  localparam logic [GRP_W:0] NG_L = NUM_GROUPS[GRP_W:0];

  logic             top_ok;
  logic             mid_ok;
  logic             b4_ok;
  logic [OFF_W-1:0] off;

  always_comb begin
    top_ok = addr[ADDR_W-1];
    mid_ok = (addr[ADDR_W-2:OFF_W] == BASE_ADDR[ADDR_W-2:OFF_W]);
    b4_ok  = mode_wide || (addr[OFF_W-1] == BASE_ADDR[OFF_W-1]);
    hit    = top_ok && mid_ok && b4_ok;
    off    = mode_wide ? addr[OFF_W-1:0] : {1'b0, addr[OFF_W-2:0]};
    grp    = off[OFF_W-1:2];
    sel    = reg_sel_e'(off[1:0]);
    mapped = ({1'b0, grp} < NG_L);
  end

endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_bank_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int LINES = 3 * PORT_W,
  localparam int HALF = PORT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [7:0]        wdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  output logic [PORT_W-1:0] rd_val
);

  logic [PORT_W-1:0] lat_a, lat_b, lat_c;
  dir_t              dir_q;
  logic [PORT_W-1:0] c_in_mask;
  logic [PORT_W-1:0] in_a, in_b, in_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      dir_q <= '1;
    end else if (wr_en) begin
      unique case (sel)
        SEL_A:   lat_a <= wdata[PORT_W-1:0];
        SEL_B:   lat_b <= wdata[PORT_W-1:0];
        SEL_C:   lat_c <= wdata[PORT_W-1:0];
        SEL_CTL: begin
          if (wdata[CTL_LOAD_BIT]) begin
            dir_q <= ctl_to_dir(wdata);
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    c_in_mask = {{HALF{dir_q.cu_in}}, {HALF{dir_q.cl_in}}};
    in_a      = pin_in[0 +: PORT_W];
    in_b      = pin_in[PORT_W +: PORT_W];
    in_c      = pin_in[2*PORT_W +: PORT_W];
    pin_out   = {lat_c, lat_b, lat_a};
    pin_oe    = {~c_in_mask, {PORT_W{~dir_q.b_in}}, {PORT_W{~dir_q.a_in}}};
    unique case (sel)
      SEL_A:   rd_val = dir_q.a_in ? in_a : lat_a;
      SEL_B:   rd_val = dir_q.b_in ? in_b : lat_b;
      SEL_C:   rd_val = (in_c & c_in_mask) | (lat_c & ~c_in_mask);
      default: rd_val = '1;
    endcase
  end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h2C0,
  localparam int GRP_LINES = 3 * PORT_W,
  localparam int LINES = NUM_GROUPS * GRP_LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic [7:0]        rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe
);

  localparam int OFF_W = 5;
  localparam int GRP_W = OFF_W - 2;

  logic             dec_hit;
  logic             dec_mapped;
  logic [GRP_W-1:0] dec_grp;
  reg_sel_e         dec_sel;

  logic [PORT_W-1:0] grp_rd [NUM_GROUPS];
  logic [7:0]        rd_mux;

  pio_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .NUM_GROUPS(NUM_GROUPS), .OFF_W(OFF_W)
  ) u_dec (
    .mode_wide(mode_wide), .addr(addr),
    .hit(dec_hit), .mapped(dec_mapped), .grp(dec_grp), .sel(dec_sel)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic grp_wr;
    assign grp_wr = wr_stb && dec_hit && (dec_grp == GRP_W'(g));
    pio_group #(.PORT_W(PORT_W)) u_grp (
      .clk(clk), .rst(rst), .wr_en(grp_wr), .sel(dec_sel), .wdata(wdata),
      .pin_in(pin_in[g*GRP_LINES +: GRP_LINES]),
      .pin_out(pin_out[g*GRP_LINES +: GRP_LINES]),
      .pin_oe(pin_oe[g*GRP_LINES +: GRP_LINES]),
      .rd_val(grp_rd[g])
    );
  end

  always_comb begin
    rd_mux = '1;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (dec_grp == GRP_W'(g)) rd_mux = grp_rd[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata <= '0;
    else if (rd_stb && dec_hit) rdata <= rd_mux;
  end

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
  parameter int NUM_GROUPS = 6,
  parameter int PORT_W = 8,
  localparam int GL = 3 * PORT_W,
  localparam int LINES = NUM_GROUPS * GL,
  localparam int GRP_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic [LINES-1:0] pin_out,
  input logic [LINES-1:0] pin_oe,
  input logic             hit,
  input logic             mapped,
  input logic [GRP_W-1:0] grp,
  input logic [1:0]       sel
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && rdata == 8'h00)); // R1

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !hit) |=> ($stable(pin_out) && $stable(pin_oe))); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && hit) |=> $stable(rdata)); // R11

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && hit && (!mapped || sel == 2'd3)) |=> (rdata == 8'hFF)); // R9

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_OE_PORT_A: assert property (@(posedge clk) disable iff (rst)
      (pin_oe[g*GL +: PORT_W] == '0 || pin_oe[g*GL +: PORT_W] == '1)); // R5
    AST_OE_PORT_B: assert property (@(posedge clk) disable iff (rst)
      (pin_oe[g*GL+PORT_W +: PORT_W] == '0 || pin_oe[g*GL+PORT_W +: PORT_W] == '1)); // R5
    AST_CTL_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && hit && grp == GRP_W'(g) && sel == 2'd3 && wdata[7])
        |=> (pin_out[g*GL +: GL] == '0)); // R6
  end

endmodule

bind pio_bank pio_bank_chk #(.NUM_GROUPS(NUM_GROUPS), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .hit(dec_hit), .mapped(dec_mapped), .grp(dec_grp), .sel(dec_sel)
);

// File: tb/pio_bank_test.sv
module pio_bank_test;

  localparam int NG = 6;
  localparam int LINES = NG * 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_wide = 1'b1;
  logic [9:0]       addr = '0;
  logic [7:0]       wdata = '0;
  logic             rd_stb = 1'b0;
  logic             wr_stb = 1'b0;
  logic [7:0]       rdata;
  logic [LINES-1:0] pin_in;
  logic [LINES-1:0] pin_out;
  logic [LINES-1:0] pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_bank uut (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .addr(addr), .wdata(wdata),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {req[3:0], is_read, addr[9:0], wdata[7:0], expect[7:0]}
  localparam int NV = 20;
  localparam logic [30:0] VEC [NV] = '{
    {4'd7,  1'b1, 10'h2C0, 8'h00, 8'h30}, // R7 group 0 A input after reset
    {4'd3,  1'b1, 10'h2D6, 8'h00, 8'h41}, // R3 group 5 port C
    {4'd5,  1'b0, 10'h2C3, 8'h80, 8'h00}, // R5 group 0 all outputs
    {4'd10, 1'b0, 10'h2C0, 8'h5A, 8'h00}, // R10
    {4'd8,  1'b1, 10'h2C0, 8'h00, 8'h5A}, // R8 output readback
    {4'd10, 1'b0, 10'h2C2, 8'hC3, 8'h00},
    {4'd8,  1'b1, 10'h2C2, 8'h00, 8'hC3}, // R8
    {4'd6,  1'b0, 10'h2C3, 8'h89, 8'h00}, // R6 clears latches, C input
    {4'd6,  1'b1, 10'h2C0, 8'h00, 8'h00}, // R6
    {4'd5,  1'b1, 10'h2C2, 8'h00, 8'h32}, // R5 both C halves input
    {4'd5,  1'b0, 10'h2C3, 8'h88, 8'h00}, // C upper in, lower out
    {4'd10, 1'b0, 10'h2C2, 8'hFF, 8'h00},
    {4'd8,  1'b1, 10'h2C2, 8'h00, 8'h3F}, // R8 split port C
    {4'd9,  1'b1, 10'h2D8, 8'h00, 8'hFF}, // R9 offset 24
    {4'd9,  1'b1, 10'h2C3, 8'h00, 8'hFF}, // R9 control offset
    {4'd6,  1'b0, 10'h2C3, 8'h00, 8'h00}, // bit 7 clear: no effect
    {4'd6,  1'b1, 10'h2C2, 8'h00, 8'h3F}, // R6 latch kept
    {4'd2,  1'b1, 10'h2E0, 8'h00, 8'h3F}, // R2 outside window, hold
    {4'd2,  1'b1, 10'h0C0, 8'h00, 8'h3F}, // R2 bit 9 low, hold
    {4'd3,  1'b1, 10'h2D0, 8'h00, 8'h3C}  // R3 bit 4 is offset, group 4 A
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NG * 3; k++) pin_in[k*8 +: 8] = 8'h30 + 8'(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(1, 32'(pin_oe[23:0]), 32'h0);
    chk(1, 32'(pin_out[23:0]), 32'h0);
    chk(1, 32'(rdata), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) begin
        bus_read(VEC[i][25:16]);
        chk(int'(VEC[i][30:27]), 32'(rdata), 32'(VEC[i][7:0]));
      end else begin
        bus_write(VEC[i][25:16], VEC[i][15:8]);
      end
    end

    // R5 group 0: A out, B out, C upper in, C lower out
    chk(5, 32'(pin_oe[23:0]), 32'h0FFFFF);
    // R10 latches on pins
    chk(10, 32'(pin_out[23:0]), 32'hFF0000);
    // R6 other groups untouched by group 1 control write
    bus_write(10'h2C7, 8'h80);
    chk(6, 32'(pin_oe[47:24]), 32'hFFFFFF);
    chk(6, 32'(pin_oe[23:0]), 32'h0FFFFF);
    // R7 live pin read
    bus_read(10'h2C8);
    chk(7, 32'(rdata), 32'h36);
    @(negedge clk); pin_in[55:48] = 8'h9C;
    bus_read(10'h2C8);
    chk(7, 32'(rdata), 32'h9C);
    // R10 write to input port updates latch, enable stays low
    bus_write(10'h2CC, 8'h77);
    chk(10, 32'(pin_out[79:72]), 32'h77);
    chk(10, 32'(pin_oe[79:72]), 32'h0);
    // R4 narrow layout
    mode_wide = 1'b0;
    bus_read(10'h2CD);
    chk(4, 32'(rdata), 32'h3A);
    bus_read(10'h2D0);
    chk(4, 32'(rdata), 32'h3A);
    bus_write(10'h2D7, 8'h80);
    chk(4, 32'(pin_oe[143:120]), 32'h0);
    bus_read(10'h2C0);
    chk(4, 32'(rdata), 32'h00);
    // R11 hold with no strobe
    repeat (3) @(negedge clk);
    chk(11, 32'(rdata), 32'h00);
    // R1 reset mid-run
    mode_wide = 1'b1;
    bus_read(10'h2C2);
    chk(8, 32'(rdata), 32'h3F);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(1, 32'(pin_oe[47:0]), 32'h0);
    chk(1, 32'(pin_out[79:72]), 32'h0);
    chk(1, 32'(rdata), 32'h0);
    finish_run();
  end

endmodule